// File: doc/BRIEF.md
# Segment Translation Unit

This block turns a logical address, given as a 16-bit selector plus a 32-bit offset, into a 32-bit linear address. The selector carries a segment number, a flag that picks one of two descriptor tables (global or local), and a two-bit request-level field. Each table holds descriptors, and each descriptor has the following fields:

- a base address
- a segment length (the limit)
- a valid bit
- separate read, write and execute permissions

Each table also has its own length register. That register says how many segment numbers are legal in the table.

Software fills the descriptors and sets the length registers through a write port. A requester then presents a selector, an offset and an access type. Exactly one cycle later the block returns either the translated address or an encoded fault cause. The descriptors are held in internal registers, so no memory fetch takes place.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0, both length registers are 0 and every descriptor is invalid. Any request therefore returns fault code 1.
- R2: A request accepted with `req_valid`=1 on a clock edge produces `rsp_valid`=1 with its result on the next edge. `rsp_valid` is 0 in every cycle that follows an edge with `req_valid`=0.
- R3: A segment number that is not below the selected table's length register, or not below the table depth, returns fault code 1 (length).
- R4: A legal segment whose descriptor has its valid bit at 0 returns fault code 2 (invalid).
- R5: An offset greater than or equal to the descriptor limit returns fault code 3 (limit).
- R6: Access type codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. An access whose permission bit is clear returns fault code 4 (privilege). Code 3 is never permitted.
- R7: When no check fails, the fault code is 0 and `rsp_addr` equals base plus offset modulo 2^32.
- R8: Whenever the fault code is not 0, `rsp_addr` is 0.
- R9: Selector bit 2 selects the table (1 = local, 0 = global). The two tables and their length registers are independent, and a length register changes only when it is written.
- R10: When several checks fail, the reported cause follows the priority length, then invalid, then limit, then privilege.
- R11: Selector bits 15:3 hold the segment number. Selector bits 1:0 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_local | input | 1 | Descriptor write target: 1 = local, 0 = global |
| cfg_idx | input | IDX_W | Descriptor index to write |
| cfg_base | input | 32 | Base address of the descriptor |
| cfg_limit | input | 32 | Segment length of the descriptor |
| cfg_valid | input | 1 | Valid bit of the descriptor |
| cfg_rd | input | 1 | Read permission |
| cfg_wr | input | 1 | Write permission |
| cfg_ex | input | 1 | Execute permission |
| len_we | input | 1 | Length register write strobe |
| len_local | input | 1 | Length register target: 1 = local, 0 = global |
| len_val | input | 14 | New length value |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 16 | Selector: [15:3] segment, [2] table flag, [1:0] level |
| req_off | input | 32 | Offset into the segment |
| req_acc | input | 2 | Access type code |
| rsp_valid | output | 1 | Result valid |
| rsp_addr | output | 32 | Linear address, or 0 on a fault |
| rsp_fault | output | 3 | Fault cause: 0 none, 1 length, 2 invalid, 3 limit, 4 privilege |

## Verification
The hardest cases to reach from the ports are those where several checks fail at once, because only the top-priority cause is visible. The stimulus builds descriptors that break two or three rules together, such as an invalid entry combined with an out-of-range offset and a forbidden access. A segment number above the table depth is also hard to reach, since it requires a length register raised beyond that depth, and the stimulus sets one up. Finally, a base near the top of the address space is paired with a large offset to exercise the 32-bit wrap of the sum.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int OFF_W  = 32;
    localparam int SEGN_W = 13;
    localparam int SEL_W  = 16;
    localparam int LEN_W  = SEGN_W + 1;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_LENGTH  = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PRIV    = 3'd4
    } fault_e;

    typedef struct packed {
        logic [OFF_W-1:0] base;
        logic [OFF_W-1:0] limit;
        logic             valid;
        logic             can_rd;
        logic             can_wr;
        logic             can_ex;
    } desc_t;

    typedef struct packed {
        logic [SEGN_W-1:0] segn;
        logic              is_local;
        logic [1:0]        rqlvl;
    } sel_t;

    function automatic logic acc_permitted(desc_t d, acc_e a);
        case (a)
            ACC_READ:  return d.can_rd;
            ACC_WRITE: return d.can_wr;
            ACC_EXEC:  return d.can_ex;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  desc_t             wr_desc,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic [SEGN_W-1:0] rd_segn,
    output desc_t             rd_desc,
    output logic              rd_legal
);

    desc_t             entries [DEPTH];
    logic [LEN_W-1:0]  len_q;
    logic              in_depth;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
        end else begin
            if (len_we) len_q <= len_val;
            if (wr_en && (int'(wr_idx) < DEPTH)) entries[wr_idx] <= wr_desc;
        end
    end

    assign in_depth = (int'(rd_segn) < DEPTH);
    assign rd_legal = in_depth && ({1'b0, rd_segn} < len_q);

    always_comb begin
        rd_desc = '0;
        if (in_depth) rd_desc = entries[rd_segn[IDX_W-1:0]];
    end

    a_r1_len_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (len_q == '0));

    a_r9_len_holds: assert property (@(posedge clk) disable iff (rst)
        !len_we |=> $stable(len_q));

endmodule

// File: rtl/seg_fault_eval.sv
module seg_fault_eval
    import seg_xlate_pkg::*;
(
    input  logic             legal,
    input  desc_t            desc,
    input  logic [OFF_W-1:0] off,
    input  acc_e             acc,
    output fault_e           fault,
    output logic [OFF_W-1:0] lin_addr
);

    logic over_limit;
    logic denied;

    assign over_limit = (off >= desc.limit);
    assign denied     = !acc_permitted(desc, acc);

    always_comb begin
        if (!legal)           fault = FLT_LENGTH;
        else if (!desc.valid) fault = FLT_INVALID;
        else if (over_limit)  fault = FLT_LIMIT;
        else if (denied)      fault = FLT_PRIV;
        else                  fault = FLT_NONE;
    end

    assign lin_addr = (fault == FLT_NONE) ? (desc.base + off) : '0;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_local,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_base,
    input  logic [31:0]      cfg_limit,
    input  logic             cfg_valid,
    input  logic             cfg_rd,
    input  logic             cfg_wr,
    input  logic             cfg_ex,
    input  logic             len_we,
    input  logic             len_local,
    input  logic [13:0]      len_val,
    input  logic             req_valid,
    input  logic [15:0]      req_sel,
    input  logic [31:0]      req_off,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic [31:0]      rsp_addr,
    output logic [2:0]       rsp_fault
);

    localparam int NTBL = 2;

    sel_t   sel;
    desc_t  new_desc;
    desc_t  tbl_desc  [NTBL];
    logic   tbl_legal [NTBL];
    desc_t  sel_desc;
    logic   sel_legal;
    fault_e cur_fault;
    logic [OFF_W-1:0] cur_addr;

    assign sel      = sel_t'(req_sel);
    assign new_desc = '{base: cfg_base, limit: cfg_limit, valid: cfg_valid,
                        can_rd: cfg_rd, can_wr: cfg_wr, can_ex: cfg_ex};

    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        seg_desc_table #(.DEPTH(DEPTH)) u_tbl (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (cfg_we && (cfg_local == (t == 1))),
            .wr_idx   (cfg_idx),
            .wr_desc  (new_desc),
            .len_we   (len_we && (len_local == (t == 1))),
            .len_val  (len_val),
            .rd_segn  (sel.segn),
            .rd_desc  (tbl_desc[t]),
            .rd_legal (tbl_legal[t])
        );
    end

    assign sel_desc  = sel.is_local ? tbl_desc[1]  : tbl_desc[0];
    assign sel_legal = sel.is_local ? tbl_legal[1] : tbl_legal[0];

    seg_fault_eval u_eval (
        .legal    (sel_legal),
        .desc     (sel_desc),
        .off      (req_off),
        .acc      (acc_e'(req_acc)),
        .fault    (cur_fault),
        .lin_addr (cur_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_addr  <= cur_addr;
                rsp_fault <= cur_fault;
            end
        end
    end

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_addr == '0));

    a_r3_length_first: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sel_legal) |=> (rsp_fault == FLT_LENGTH));

    a_r4_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !sel_desc.valid) |=> (rsp_fault != FLT_NONE));

    a_r5_within_limit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_off >= sel_desc.limit) |=> (rsp_fault != FLT_NONE));

endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_local = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0, cfg_limit = '0;
    logic        cfg_valid = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0, cfg_ex = 1'b0;
    logic        len_we = 1'b0, len_local = 1'b0;
    logic [13:0] len_val = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_fault;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    seg_xlate_unit i_seg_xlate_unit (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_local(cfg_local), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_ex(cfg_ex),
        .len_we(len_we), .len_local(len_local), .len_val(len_val),
        .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
        .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_sel(int segn, bit loc, logic [1:0] lvl);
        return {segn[12:0], loc, lvl};
    endfunction

    task automatic put_desc(bit loc, int idx, logic [31:0] base, logic [31:0] lim,
                            bit v, bit r, bit w, bit x);
        @(negedge clk);
        cfg_we = 1'b1; cfg_local = loc; cfg_idx = idx[3:0];
        cfg_base = base; cfg_limit = lim;
        cfg_valid = v; cfg_rd = r; cfg_wr = w; cfg_ex = x;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_len(bit loc, int n);
        @(negedge clk);
        len_we = 1'b1; len_local = loc; len_val = n[13:0];
        @(negedge clk);
        len_we = 1'b0;
    endtask

    // Drive at a falling edge, register at the rising edge, sample at the next falling edge.
    task automatic xlate(string tag, logic [15:0] s, logic [31:0] off, logic [1:0] acc,
                         logic [2:0] exp_flt, logic [31:0] exp_addr);
        @(negedge clk);
        req_valid = 1'b1; req_sel = s; req_off = off; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 valid"}, {31'b0, rsp_valid}, 32'd1);
        check({tag, " fault"}, {29'b0, rsp_fault}, {29'b0, exp_flt});
        check({tag, " addr"}, rsp_addr, exp_addr);
    endtask

    task automatic t_reset;
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        xlate("R1 global seg0 empty", mk_sel(0, 0, 0), 0, 0, 3'd1, 0);
        xlate("R1 local seg0 empty", mk_sel(0, 1, 0), 0, 0, 3'd1, 0);
    endtask

    task automatic t_setup;
        put_len(0, 4);
        put_desc(0, 0, 32'h0000_1000, 32'h100, 1, 1, 1, 1);
        put_desc(0, 1, 32'h0000_8000, 32'h100, 0, 1, 1, 1);
        put_desc(0, 2, 32'hFFFF_FF00, 32'h1000, 1, 1, 0, 0);
        put_desc(0, 3, 32'h0002_0000, 32'h40, 1, 0, 0, 1);
        put_len(1, 2);
        put_desc(1, 0, 32'h5000_0000, 32'h10, 1, 1, 1, 0);
        put_desc(1, 1, 32'h0, 32'hFFFF_FFFF, 1, 1, 1, 1);
    endtask

    task automatic t_translate;
        xlate("R7 global read", mk_sel(0, 0, 0), 32'h20, 2'd0, 3'd0, 32'h1020);
        xlate("R7 local write", mk_sel(0, 1, 0), 32'h4, 2'd1, 3'd0, 32'h5000_0004);
        xlate("R7 wrap sum", mk_sel(2, 0, 0), 32'h200, 2'd0, 3'd0, 32'h100);
        xlate("R7 last byte", mk_sel(0, 0, 0), 32'hFF, 2'd0, 3'd0, 32'h10FF);
    endtask

    task automatic t_length;
        xlate("R3 at length", mk_sel(4, 0, 0), 0, 0, 3'd1, 0);
        xlate("R3 local at length", mk_sel(2, 1, 0), 0, 0, 3'd1, 0);
        put_len(0, 100);
        xlate("R3 beyond depth", mk_sel(20, 0, 0), 0, 0, 3'd1, 0);
        put_len(0, 4);
    endtask

    task automatic t_invalid;
        xlate("R4 invalid entry", mk_sel(1, 0, 0), 32'h10, 2'd0, 3'd2, 0);
    endtask

    task automatic t_limit;
        xlate("R5 offset at limit", mk_sel(0, 0, 0), 32'h100, 2'd0, 3'd3, 0);
        xlate("R5 local over limit", mk_sel(0, 1, 0), 32'h11, 2'd0, 3'd3, 0);
    endtask

    task automatic t_priv;
        xlate("R6 write to read-only", mk_sel(2, 0, 0), 32'h0, 2'd1, 3'd4, 0);
        xlate("R6 read exec-only", mk_sel(3, 0, 0), 32'h0, 2'd0, 3'd4, 0);
        xlate("R6 exec ok", mk_sel(3, 0, 0), 32'h8, 2'd2, 3'd0, 32'h0002_0008);
        xlate("R6 reserved code", mk_sel(0, 0, 0), 32'h0, 2'd3, 3'd4, 0);
        xlate("R6 local exec denied", mk_sel(0, 1, 0), 32'h0, 2'd2, 3'd4, 0);
    endtask

    task automatic t_priority;
        xlate("R10 length over invalid", mk_sel(5, 0, 0), 32'hFFFF_FFFF, 2'd3, 3'd1, 0);
        xlate("R10 invalid over limit", mk_sel(1, 0, 0), 32'h9999, 2'd3, 3'd2, 0);
        xlate("R10 limit over priv", mk_sel(2, 0, 0), 32'h2000, 2'd1, 3'd3, 0);
    endtask

    task automatic t_tables;
        xlate("R9 local seg1 full range", mk_sel(1, 1, 0), 32'hFFFF_FFFE, 2'd1, 3'd0, 32'hFFFF_FFFE);
        put_len(1, 0);
        xlate("R9 global kept length", mk_sel(3, 0, 0), 32'h0, 2'd2, 3'd0, 32'h0002_0000);
        xlate("R9 local length cleared", mk_sel(0, 1, 0), 32'h0, 2'd0, 3'd1, 0);
        put_len(1, 2);
        xlate("R9 local restored", mk_sel(0, 1, 0), 32'h1, 2'd0, 3'd0, 32'h5000_0001);
    endtask

    task automatic t_level;
        xlate("R11 level 3 ok", mk_sel(0, 0, 3), 32'h30, 2'd0, 3'd0, 32'h1030);
        xlate("R11 level 2 limit", mk_sel(0, 0, 2), 32'h100, 2'd0, 3'd3, 0);
        xlate("R11 level 1 priv", mk_sel(2, 0, 1), 32'h0, 2'd1, 3'd4, 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        check("R2 idle no response", {31'b0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setup();
        t_translate();
        t_length();
        t_invalid();
        t_limit();
        t_priv();
        t_priority();
        t_tables();
        t_level();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule